// File: doc/BRIEF.md
# Z80 Paged Memory Address Decoder

This block sits between a Z80 CPU and two memories: a small boot ROM and a single 128 KB asynchronous SRAM. On every memory cycle it decides which of the two is enabled and forms the top two bits of the 17-bit SRAM address. The CPU map has three regions. The lowest 2 KB belongs to the ROM. The span from 0x0800 to 0x7FFF is ordinary RAM at the same addresses in the SRAM. The upper 32 KB is a window that shows one of three 32 KB SRAM banks.

Software picks the bank with an OUT instruction to one I/O port. The two low data bits of that write hold the bank code. A code of zero would expose the low SRAM a second time, so it is stored as bank 1. An IN from the same port returns the bank now in use. The SRAM address lines A14..A0 connect straight to the CPU. The decoder drives only A16..A15 and the ROM and SRAM strobes.

Top module: `paged_mem_decode`

## Requirements
- R1: During a memory cycle (mreq_n low, rfsh_n high) at an address below ROM_BYTES (default 0x0800), rom_cs_n is low and ram_cs_n is high.
- R2: During a memory cycle at 0x0800..0x7FFF, ram_cs_n is low, rom_cs_n is high and ram_hi_addr is 2'b00.
- R3: During a memory cycle at 0x8000..0xFFFF, ram_cs_n is low and ram_hi_addr (SRAM A16:A15) equals the stored bank code (01, 10 or 11 for SRAM bases 0x08000, 0x10000 and 0x18000).
- R4: After reset the stored bank code is 2'b01.
- R5: An I/O write (iorq_n low, wr_n low, m1_n high, cpu_addr[7:0] == PORT_NUM, default 0x1C) loads cpu_din[1:0] into the bank register at the next rising clock edge. Data bits 7..2 are ignored.
- R6: A bank-port write with cpu_din[1:0] == 2'b00 stores 2'b01.
- R7: An I/O write is ignored when the port number differs, when m1_n is low (interrupt acknowledge), or when the cycle is a memory write (iorq_n high).
- R8: Both chip selects stay high when mreq_n is high or rfsh_n is low.
- R9: ram_oe_n is low only while ram_cs_n and rd_n are both low. ram_we_n is low only while ram_cs_n and wr_n are both low. A ROM access never lowers either of them.
- R10: An I/O read of the bank port (iorq_n low, rd_n low, m1_n high, matching port) raises cpu_dout_en and puts {6'b0, bank} on cpu_dout. In every other cycle cpu_dout_en is low and cpu_dout is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_din | input | 8 | CPU data bus, value the CPU writes |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge marker, active low |
| rfsh_n | input | 1 | Refresh cycle marker, active low |
| cpu_dout | output | 8 | Bank-port read data |
| cpu_dout_en | output | 1 | High while the block drives the data bus |
| rom_cs_n | output | 1 | Boot ROM chip select |
| ram_cs_n | output | 1 | SRAM chip select |
| ram_oe_n | output | 1 | SRAM output enable |
| ram_we_n | output | 1 | SRAM write enable |
| ram_hi_addr | output | 2 | SRAM address bits A16:A15 |

## Verification
The bank register is the only state in the block. A wrong value shows up at ram_hi_addr on the very next memory cycle in the upper window, and also on the next read of the bank port. A missed write, or a write that should have been ignored but was taken, is therefore visible one clock after the I/O cycle. The bench checks it there, both through a paged access and through a port read. Region decoding has no state, so the bench checks each address boundary (0x07FF/0x0800 and 0x7FFF/0x8000) in the same cycle the address is applied.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  localparam int CPU_AW  = 16;
  localparam int BANK_W  = 2;
  localparam int DATA_W  = 8;
  localparam int PORT_AW = 8;

  typedef enum logic [1:0] {
    RGN_NONE  = 2'd0,
    RGN_ROM   = 2'd1,
    RGN_FIXED = 2'd2,
    RGN_PAGED = 2'd3
  } region_e;

  // Which memory a CPU address lands in, given that a memory cycle is live.
  function automatic region_e classify(input logic [CPU_AW-1:0] addr,
                                       input logic [CPU_AW-1:0] rom_limit,
                                       input logic              live);
    region_e r;
    if (!live)                r = RGN_NONE;
    else if (addr < rom_limit) r = RGN_ROM;
    else if (addr[CPU_AW-1])   r = RGN_PAGED;
    else                       r = RGN_FIXED;
    return r;
  endfunction

  // Code zero would alias low SRAM into the window; fold it onto bank 1.
  function automatic logic [BANK_W-1:0] fold_bank(input logic [BANK_W-1:0] code);
    return (code == '0) ? BANK_W'(1) : code;
  endfunction

  // Physical SRAM bits above the 32 KB window offset.
  function automatic logic [BANK_W-1:0] upper_bits(input region_e r,
                                                   input logic [BANK_W-1:0] bank);
    return (r == RGN_PAGED) ? bank : '0;
  endfunction
endpackage

// File: rtl/pmd_io_decode.sv
module pmd_io_decode
  import pmd_pkg::*;
#(
  parameter logic [PORT_AW-1:0] PORT_NUM = 8'h1C
) (
  input  logic [PORT_AW-1:0] port_addr,
  input  logic               iorq_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               m1_n,
  output logic               port_wr,
  output logic               port_rd
);
  logic hit;
  // m1_n low with iorq_n low marks an interrupt acknowledge, not a port cycle
  assign hit     = !iorq_n && m1_n && (port_addr == PORT_NUM);
  assign port_wr = hit && !wr_n;
  assign port_rd = hit && !rd_n;
endmodule

// File: rtl/pmd_bank_reg.sv
module pmd_bank_reg
  import pmd_pkg::*;
#(
  parameter logic [BANK_W-1:0] BANK_RST = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BANK_W-1:0] code,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bank <= fold_bank(BANK_RST);
    else if (load)  bank <= fold_bank(code);
  end
endmodule

// File: rtl/pmd_mem_decode.sv
module pmd_mem_decode
  import pmd_pkg::*;
#(
  parameter int ROM_BYTES = 2048
) (
  input  logic [CPU_AW-1:0] addr,
  input  logic              mreq_n,
  input  logic              rfsh_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [BANK_W-1:0] bank,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [BANK_W-1:0] hi_addr
);
  localparam logic [CPU_AW-1:0] ROM_LIMIT = CPU_AW'(ROM_BYTES);

  region_e rgn;
  logic    ram_sel;

  assign rgn      = classify(addr, ROM_LIMIT, !mreq_n && rfsh_n);
  assign ram_sel  = (rgn == RGN_FIXED) || (rgn == RGN_PAGED);
  assign rom_cs_n = !(rgn == RGN_ROM);
  assign ram_cs_n = !ram_sel;
  assign ram_oe_n = !(ram_sel && !rd_n);
  assign ram_we_n = !(ram_sel && !wr_n);
  assign hi_addr  = upper_bits(classify(addr, ROM_LIMIT, 1'b1), bank);
endmodule

// File: rtl/paged_mem_decode.sv
module paged_mem_decode
  import pmd_pkg::*;
#(
  parameter int                 ROM_BYTES = 2048,
  parameter logic [PORT_AW-1:0] PORT_NUM  = 8'h1C,
  parameter logic [BANK_W-1:0]  BANK_RST  = 2'b01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_din,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  input  logic              rfsh_n,
  output logic [DATA_W-1:0] cpu_dout,
  output logic              cpu_dout_en,
  output logic              rom_cs_n,
  output logic              ram_cs_n,
  output logic              ram_oe_n,
  output logic              ram_we_n,
  output logic [BANK_W-1:0] ram_hi_addr
);
  logic              port_wr;
  logic              port_rd;
  logic [BANK_W-1:0] bank_q;
  logic              unused_din_hi;

  assign unused_din_hi = ^cpu_din[DATA_W-1:BANK_W];

  pmd_io_decode #(.PORT_NUM(PORT_NUM)) u_io (
    .port_addr (cpu_addr[PORT_AW-1:0]),
    .iorq_n    (iorq_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .m1_n      (m1_n),
    .port_wr   (port_wr),
    .port_rd   (port_rd)
  );

  pmd_bank_reg #(.BANK_RST(BANK_RST)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (port_wr),
    .code  (cpu_din[BANK_W-1:0]),
    .bank  (bank_q)
  );

  pmd_mem_decode #(.ROM_BYTES(ROM_BYTES)) u_mem (
    .addr     (cpu_addr),
    .mreq_n   (mreq_n),
    .rfsh_n   (rfsh_n),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .bank     (bank_q),
    .rom_cs_n (rom_cs_n),
    .ram_cs_n (ram_cs_n),
    .ram_oe_n (ram_oe_n),
    .ram_we_n (ram_we_n),
    .hi_addr  (ram_hi_addr)
  );

  assign cpu_dout_en = port_rd;
  assign cpu_dout    = port_rd ? {{(DATA_W-BANK_W){1'b0}}, bank_q} : '0;
endmodule

// File: rtl/pmd_checker.sv
module pmd_checker
  import pmd_pkg::*;
#(
  parameter int ROM_BYTES = 2048
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_din,
  input logic              mreq_n,
  input logic              rfsh_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic              rom_cs_n,
  input logic              ram_cs_n,
  input logic              ram_oe_n,
  input logic              ram_we_n,
  input logic [BANK_W-1:0] ram_hi_addr,
  input logic              port_wr,
  input logic [BANK_W-1:0] bank_q
);
  // R1
  rom_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && rfsh_n && (cpu_addr < CPU_AW'(ROM_BYTES))) |-> (!rom_cs_n && ram_cs_n));
  // R2
  fixed_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && !cpu_addr[CPU_AW-1]) |-> (ram_hi_addr == '0));
  // R3
  paged_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && cpu_addr[CPU_AW-1]) |-> (ram_hi_addr == bank_q));
  // R5
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && $past(rst_n) && (cpu_din[1:0] != 2'b00)) |=> (bank_q == $past(cpu_din[1:0])));
  // R6
  bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q != 2'b00);
  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr |=> $stable(bank_q));
  // R8
  idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_n || !rfsh_n) |-> (rom_cs_n && ram_cs_n));
  // R9
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_oe_n || !ram_we_n) |-> (!ram_cs_n && rom_cs_n));
  // R9
  we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> !wr_n);
endmodule

bind paged_mem_decode pmd_checker #(.ROM_BYTES(ROM_BYTES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .cpu_din     (cpu_din),
  .mreq_n      (mreq_n),
  .rfsh_n      (rfsh_n),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .rom_cs_n    (rom_cs_n),
  .ram_cs_n    (ram_cs_n),
  .ram_oe_n    (ram_oe_n),
  .ram_we_n    (ram_we_n),
  .ram_hi_addr (ram_hi_addr),
  .port_wr     (port_wr),
  .bank_q      (bank_q)
);

// File: tb/paged_mem_decode_test.sv
`timescale 1ns/1ps
module paged_mem_decode_test;
  localparam logic [7:0] PORT = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_din = '0;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic        m1_n = 1'b1, rfsh_n = 1'b1;
  logic [7:0]  cpu_dout;
  logic        cpu_dout_en, rom_cs_n, ram_cs_n, ram_oe_n, ram_we_n;
  logic [1:0]  ram_hi_addr;

  always #4 clk = ~clk;

  paged_mem_decode uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
    .m1_n(m1_n), .rfsh_n(rfsh_n), .cpu_dout(cpu_dout),
    .cpu_dout_en(cpu_dout_en), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n), .ram_hi_addr(ram_hi_addr)
  );

  typedef struct {
    string      tag;
    logic       rom_n, ram_n, oe_n, we_n, den;
    logic [1:0] hi;
    logic [7:0] dout;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   total = 0, bad = 0;
  logic [1:0] model_bank;
  bit   done = 0;

  // Expected port values, written from the requirement text.
  function automatic exp_t predict(string tag, logic [15:0] a, logic mq, logic rf,
                                   logic io, logic rd, logic wr, logic m1,
                                   logic [1:0] bk);
    exp_t e;
    bit live, in_rom, in_ram, port_rd;
    e.tag  = tag;
    live   = (mq == 1'b0) && (rf == 1'b1);
    in_rom = live && (a <= 16'h07FF);
    in_ram = live && (a >= 16'h0800);
    e.rom_n = in_rom ? 1'b0 : 1'b1;
    e.ram_n = in_ram ? 1'b0 : 1'b1;
    e.oe_n  = (in_ram && rd == 1'b0) ? 1'b0 : 1'b1;
    e.we_n  = (in_ram && wr == 1'b0) ? 1'b0 : 1'b1;
    e.hi    = (a >= 16'h8000) ? bk : 2'b00;
    port_rd = (io == 1'b0) && (rd == 1'b0) && (m1 == 1'b1) && (a[7:0] == PORT);
    e.den   = port_rd;
    e.dout  = port_rd ? {6'b000000, bk} : 8'h00;
    return e;
  endfunction

  always @(chk_ev) begin
    exp_t e;
    while (q.size() > 0) begin
      e = q.pop_front();
      total++;
      if ({rom_cs_n, ram_cs_n, ram_oe_n, ram_we_n, cpu_dout_en, ram_hi_addr, cpu_dout} !==
          {e.rom_n, e.ram_n, e.oe_n, e.we_n, e.den, e.hi, e.dout}) begin
        bad++;
        $display("FAIL %s: got rom=%b ram=%b oe=%b we=%b den=%b hi=%b dout=%h exp rom=%b ram=%b oe=%b we=%b den=%b hi=%b dout=%h",
          e.tag, rom_cs_n, ram_cs_n, ram_oe_n, ram_we_n, cpu_dout_en, ram_hi_addr, cpu_dout,
          e.rom_n, e.ram_n, e.oe_n, e.we_n, e.den, e.hi, e.dout);
      end
    end
  end

  task automatic idle();
    mreq_n = 1; iorq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1; rfsh_n = 1;
  endtask

  // Apply one bus state after a falling edge and queue its expected outputs.
  task automatic drive(string tag, logic [15:0] a, logic mq, logic rf, logic io,
                       logic rd, logic wr, logic m1, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; mreq_n = mq; rfsh_n = rf; iorq_n = io; rd_n = rd; wr_n = wr;
    m1_n = m1; cpu_din = d;
    #1;
    q.push_back(predict(tag, a, mq, rf, io, rd, wr, m1, model_bank));
    -> chk_ev;
    #1;
  endtask

  // I/O or memory write held across one rising edge; model updated if it should load.
  task automatic bus_write(string tag, logic [15:0] a, logic mq, logic io, logic m1,
                           logic [7:0] d, bit should_load);
    drive(tag, a, mq, 1'b1, io, 1'b1, 1'b0, m1, d);
    @(negedge clk);
    idle();
    if (should_load) model_bank = (d[1:0] == 2'b00) ? 2'b01 : d[1:0];
  endtask

  task automatic mem_rd(string tag, logic [15:0] a);
    drive(tag, a, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
  endtask

  task automatic port_rd(string tag);
    drive(tag, {8'h00, PORT}, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
  endtask

  initial begin
    model_bank = 2'b01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4 reset value seen through window and port
    mem_rd("R4 reset bank via window", 16'hC000);
    port_rd("R4 reset bank via port");
    // R1 ROM region and its top edge
    mem_rd("R1 rom at 0000", 16'h0000);
    mem_rd("R1 rom at 07FF", 16'h07FF);
    // R2 fixed RAM edges
    mem_rd("R2 fixed at 0800", 16'h0800);
    mem_rd("R2 fixed at 7FFF", 16'h7FFF);
    // R9 memory writes: ROM write lowers no strobe, RAM write lowers we
    drive("R9 write to rom", 16'h0100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h55);
    drive("R9 write to fixed ram", 16'h4000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h55);
    // R8 refresh and no-request cycles
    drive("R8 refresh cycle", 16'h9000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00);
    drive("R8 no mreq", 16'h9000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
    // R5 and R3: each bank code through the window, upper data bits set
    bus_write("R5 load bank 2", {8'h00, PORT}, 1'b1, 1'b0, 1'b1, 8'hFE, 1'b1);
    mem_rd("R3 window 8000 bank 2", 16'h8000);
    port_rd("R10 readback bank 2");
    bus_write("R5 load bank 3", {8'hA5, PORT}, 1'b1, 1'b0, 1'b1, 8'h03, 1'b1);
    mem_rd("R3 window FFFF bank 3", 16'hFFFF);
    mem_rd("R2 fixed 7FFF ignores bank", 16'h7FFF);
    // R6 zero code folds to bank 1
    bus_write("R6 load code 00", {8'h00, PORT}, 1'b1, 1'b0, 1'b1, 8'hFC, 1'b1);
    mem_rd("R6 window after code 00", 16'hA000);
    port_rd("R6 readback after code 00");
    bus_write("R5 load bank 2 again", {8'h00, PORT}, 1'b1, 1'b0, 1'b1, 8'h02, 1'b1);
    // R7 ignored writes
    bus_write("R7 wrong port", {8'h00, PORT ^ 8'h01}, 1'b1, 1'b0, 1'b1, 8'h03, 1'b0);
    mem_rd("R7 window after wrong port", 16'h8800);
    bus_write("R7 int ack cycle", {8'h00, PORT}, 1'b1, 1'b0, 1'b0, 8'h03, 1'b0);
    port_rd("R7 readback after int ack");
    bus_write("R7 memory write to port-like addr", {8'h80, PORT}, 1'b0, 1'b1, 1'b1, 8'h01, 1'b0);
    mem_rd("R7 window after memory write", 16'hF000);
    // R10 no drive on other cycles
    drive("R10 port read wrong port", 16'h001D, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
    drive("R10 port read during int ack", {8'h00, PORT}, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00);
    // R4 reset mid-run restores bank 1
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; model_bank = 2'b01;
    mem_rd("R4 window after reset", 16'hE000);
    @(negedge clk); idle();
    #2;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule